// File: doc/BRIEF.md
# HDLC NRZI Frame Bit Sequencer

This block walks through one HDLC-style frame and produces one tone decision per symbol strobe. The frame is built from four sections. First come zero octets that give the receiver a run of tone changes to lock onto. Next come opening flag octets (0x7E). Then come the payload bytes, fetched from an external byte buffer. Last come closing flag octets. Each bit becomes an NRZI command. A 0 bit requests a toggle between the two tones, and a 1 bit keeps the current tone. Inside the payload, five 1 bits in a row cause one extra toggle symbol to be inserted. The payload bit that follows is then sent one symbol later.

A controller sets `len_i` and pulses `start_i`. The modulator supplies `sym_stb_i` once per baud period and applies a tone change whenever `toggle_o` pulses. `busy_o` stays high from the start until the strobe that carries the last closing-flag bit.

The state machine has five states. **IDLE** waits for a start. **PRE** emits zero octets. **HEAD** emits opening flags. **DATA** emits payload bits and runs the ones counter. **TAIL** emits closing flags. The transitions are:
- *launch*: IDLE→PRE, on `start_i`.
- *pre_done*: PRE→HEAD.
- *head_done*: HEAD→DATA when the length is non-zero, and HEAD→TAIL when it is zero.
- *data_done*: DATA→TAIL.
- *frame_done*: TAIL→IDLE.

Every transition other than *launch* fires on the strobe that sends the last bit of a section's last octet. A pending stuff symbol is served in whatever state is current and never moves the bit position.

Top module: `hdlc_nrzi_seq`

## Requirements
- R1: After reset, `busy_o` and `toggle_o` are 0 and `rd_addr_o` is 0.
- R2: A `start_i` pulse while idle samples `len_i` and raises `busy_o` on the next cycle.
- R3: A `start_i` pulse while busy has no effect: the running frame and its length continue unchanged.
- R4: `toggle_o` is a single-cycle pulse in the cycle after a strobe taken while busy. It is never high at any other time, and a strobe while idle produces nothing.
- R5: NRZI: for a frame bit of 0, `toggle_o` pulses after the strobe; for a frame bit of 1, it stays low.
- R6: Frame order: PRE_OCTETS octets of 0x00, then HEAD_FLAGS octets of 0x7E sent MSB first, then `len` payload bytes sent LSB first, then TAIL_FLAGS octets of 0x7E sent MSB first. Each of the three section counts is at least 1.
- R7: While a payload byte is in use, `rd_addr_o` holds its index (0 to len-1) and changes only on a strobe. `rd_data_i` must return that byte one cycle after the address, and strobes must be at least 3 cycles apart.
- R8: A counter of consecutive payload 1 bits is kept, and it carries across byte boundaries. When it reaches 5, the counter clears, and the next strobe emits a toggle without advancing the bit position.
- R9: Zero and flag octets are never stuffed, so the six 1 bits of a flag produce no extra symbol.
- R10: The ones counter is cleared at every start, so 1 bits at the end of one frame's payload do not count toward stuffing in the next frame.
- R11: `busy_o` drops in the cycle after the strobe of the final closing-flag bit. The frame lasts 8·(PRE_OCTETS+HEAD_FLAGS+len+TAIL_FLAGS) symbols plus one per stuff.
- R12: With `len` = 0, the closing flags follow the opening flags directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a new frame |
| len_i | input | LEN_W | Payload length in bytes |
| sym_stb_i | input | 1 | Symbol strobe, one per baud period |
| rd_addr_o | output | LEN_W | Payload byte index |
| rd_data_i | input | 8 | Payload byte, valid one cycle after the address |
| toggle_o | output | 1 | Tone-change request pulse |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench runs random payloads of random length, with some bytes forced to 0xFF. These produce runs of 1 bits that stuff inside a byte and across byte edges, and they separate correct stuffing from missing or misplaced extra symbols.

A frame with only 0xFF bytes and a frame with length zero check the densest stuffing and the HEAD→TAIL shortcut. A pair of frames, where the first payload ends in four 1 bits and the second begins with two, shows whether the ones counter is cleared at start. A start pulse sent during a running frame with a different length must leave the decision stream unchanged. A strobe while idle must produce no toggle.

// File: rtl/hdlc_seq_pkg.sv
package hdlc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HEAD,
        ST_DATA,
        ST_TAIL
    } seq_state_t;

    localparam logic [7:0] FLAG_OCTET = 8'h7E;

endpackage

// File: rtl/hdlc_bit_pick.sv
module hdlc_bit_pick
    import hdlc_seq_pkg::*;
(
    input  seq_state_t state_i,
    input  logic [2:0] bit_idx_i,
    input  logic [7:0] byte_i,
    output logic       bit_o
);

    always_comb begin
        unique case (state_i)
            ST_PRE:           bit_o = 1'b0;
            ST_HEAD, ST_TAIL: bit_o = FLAG_OCTET[3'd7 - bit_idx_i];
            ST_DATA:          bit_o = byte_i[bit_idx_i];
            default:          bit_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/hdlc_stuffer.sv
module hdlc_stuffer #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic adv_i,
    input  logic count_i,
    input  logic bit_i,
    input  logic serve_i,
    output logic pend_o
);

    localparam int RW = $clog2(RUN_LEN + 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            pend_o <= 1'b0;
        end else if (clear_i) begin
            run_q  <= '0;
            pend_o <= 1'b0;
        end else if (serve_i) begin
            pend_o <= 1'b0;
        end else if (adv_i && count_i) begin
            if (bit_i) begin
                if (run_q == RW'(RUN_LEN - 1)) begin
                    run_q  <= '0;
                    pend_o <= 1'b1;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

endmodule

// File: rtl/hdlc_nrzi_seq.sv
module hdlc_nrzi_seq
    import hdlc_seq_pkg::*;
#(
    parameter int PRE_OCTETS = 3,
    parameter int HEAD_FLAGS = 2,
    parameter int TAIL_FLAGS = 2,
    parameter int LEN_W      = 8,
    parameter int STUFF_RUN  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             sym_stb_i,
    output logic [LEN_W-1:0] rd_addr_o,
    input  logic [7:0]       rd_data_i,
    output logic             toggle_o,
    output logic             busy_o
);

    localparam int SEC_MAX0 = (PRE_OCTETS > HEAD_FLAGS) ? PRE_OCTETS : HEAD_FLAGS;
    localparam int SEC_MAX  = (SEC_MAX0 > TAIL_FLAGS) ? SEC_MAX0 : TAIL_FLAGS;
    localparam int SEC_W    = (SEC_MAX > 1) ? $clog2(SEC_MAX) : 1;
    localparam int CNT_W    = (LEN_W > SEC_W) ? LEN_W : SEC_W;

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] oct_q;
    logic [2:0]       bit_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] sec_last;
    logic             bit_val;
    logic             stuff_pend;
    logic             strobe_act, serve, adv, launch, oct_end, sec_end;

    assign launch     = start_i && (state_q == ST_IDLE);
    assign strobe_act = sym_stb_i && (state_q != ST_IDLE);
    assign serve      = strobe_act && stuff_pend;
    assign adv        = strobe_act && !stuff_pend;
    assign oct_end    = adv && (bit_q == 3'd7);
    assign sec_end    = oct_end && (oct_q == sec_last);

    hdlc_bit_pick u_pick (
        .state_i   (state_q),
        .bit_idx_i (bit_q),
        .byte_i    (rd_data_i),
        .bit_o     (bit_val)
    );

    hdlc_stuffer #(.RUN_LEN(STUFF_RUN)) u_stuff (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (launch),
        .adv_i   (adv),
        .count_i (state_q == ST_DATA),
        .bit_i   (bit_val),
        .serve_i (serve),
        .pend_o  (stuff_pend)
    );

    // last octet index of the current section
    always_comb begin
        unique case (state_q)
            ST_PRE:  sec_last = CNT_W'(PRE_OCTETS - 1);
            ST_HEAD: sec_last = CNT_W'(HEAD_FLAGS - 1);
            ST_DATA: sec_last = CNT_W'(len_q) - CNT_W'(1);
            ST_TAIL: sec_last = CNT_W'(TAIL_FLAGS - 1);
            default: sec_last = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_PRE;
            ST_PRE:  if (sec_end) state_d = ST_HEAD;
            ST_HEAD: if (sec_end) state_d = (len_q == '0) ? ST_TAIL : ST_DATA;
            ST_DATA: if (sec_end) state_d = ST_TAIL;
            ST_TAIL: if (sec_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oct_q <= '0;
            bit_q <= '0;
            len_q <= '0;
        end else if (launch) begin
            oct_q <= '0;
            bit_q <= '0;
            len_q <= len_i;
        end else if (adv) begin
            bit_q <= bit_q + 3'd1;
            if (oct_end) oct_q <= sec_end ? '0 : oct_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) toggle_o <= 1'b0;
        else        toggle_o <= strobe_act && (stuff_pend || !bit_val);
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign rd_addr_o = oct_q[LEN_W-1:0];

endmodule

// File: rtl/hdlc_nrzi_seq_chk.sv
module hdlc_nrzi_seq_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             sym_stb_i,
    input logic [LEN_W-1:0] rd_addr_o,
    input logic             toggle_o,
    input logic             busy_o,
    input logic             stuff_pend
);

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o); // R2

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !sym_stb_i) |=> busy_o); // R3

    AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_o |-> $past(sym_stb_i && busy_o)); // R4

    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !sym_stb_i) |=> $stable(rd_addr_o)); // R7

    AST_STUFF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb_i && busy_o && stuff_pend) |=> toggle_o); // R8

    AST_PEND_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_pend |-> busy_o); // R11

endmodule

bind hdlc_nrzi_seq hdlc_nrzi_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .sym_stb_i  (sym_stb_i),
    .rd_addr_o  (rd_addr_o),
    .toggle_o   (toggle_o),
    .busy_o     (busy_o),
    .stuff_pend (stuff_pend)
);

// File: tb/tb_hdlc_nrzi_seq.sv
module tb_hdlc_nrzi_seq;

    localparam int N1 = 3;
    localparam int N2 = 2;
    localparam int N3 = 2;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [LW-1:0] len_i = '0;
    logic          sym_stb_i = 1'b0;
    logic [LW-1:0] rd_addr_o;
    logic [7:0]    rd_data_i;
    logic          toggle_o;
    logic          busy_o;

    logic [7:0] mem [256];

    int    checks = 0;
    int    fails = 0;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    always_ff @(posedge clk) rd_data_i <= mem[rd_addr_o];

    hdlc_nrzi_seq #(
        .PRE_OCTETS(N1), .HEAD_FLAGS(N2), .TAIL_FLAGS(N3), .LEN_W(LW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .sym_stb_i(sym_stb_i), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .toggle_o(toggle_o), .busy_o(busy_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push_octet_msb(logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            exp_q.push_back(int'(v[i]));
            tag_q.push_back("R6 R9 section bit");
        end
    endtask

    // expected bit stream from the requirements (R6, R8, R9)
    task automatic build_exp(int len);
        int ones;
        exp_q.delete();
        tag_q.delete();
        for (int o = 0; o < N1; o++) push_octet_msb(8'h00);
        for (int o = 0; o < N2; o++) push_octet_msb(8'h7E);
        ones = 0;
        for (int b = 0; b < len; b++) begin
            for (int i = 0; i < 8; i++) begin
                exp_q.push_back(int'(mem[b][i]));
                tag_q.push_back("R5 R7 payload bit");
                if (mem[b][i]) begin
                    ones++;
                    if (ones == 5) begin
                        ones = 0;
                        exp_q.push_back(0);
                        tag_q.push_back("R8 stuff symbol");
                    end
                end else begin
                    ones = 0;
                end
            end
        end
        for (int o = 0; o < N3; o++) push_octet_msb(8'h7E);
    endtask

    task automatic run_frame(int len, bit poke);
        @(negedge clk);
        start_i = 1'b1;
        len_i   = LW'(len);
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy after start", 32'(busy_o), 32'd1);
        build_exp(len);
        for (int k = 0; k < exp_q.size(); k++) begin
            @(negedge clk);
            sym_stb_i = 1'b1;
            @(negedge clk);
            sym_stb_i = 1'b0;
            check(tag_q[k], 32'(toggle_o), 32'(exp_q[k] == 0));
            check("R11 busy through frame", 32'(busy_o), 32'(k < exp_q.size() - 1));
            @(negedge clk);
            check("R4 no toggle between strobes", 32'(toggle_o), 32'd0);
            if (poke && k == 30) begin
                start_i = 1'b1;
                len_i   = LW'(len + 3);
            end
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy reset", 32'(busy_o), 32'd0);
        check("R1 toggle reset", 32'(toggle_o), 32'd0);
        check("R1 addr reset", 32'(rd_addr_o), 32'd0);

        // R4: strobe while idle does nothing
        sym_stb_i = 1'b1;
        @(negedge clk);
        sym_stb_i = 1'b0;
        check("R4 idle strobe", 32'(toggle_o), 32'd0);
        check("R4 idle strobe busy", 32'(busy_o), 32'd0);

        // R12: empty payload
        run_frame(0, 1'b0);

        // R8: dense stuffing across byte edges
        for (int i = 0; i < 4; i++) mem[i] = 8'hFF;
        run_frame(4, 1'b0);

        // R10: frame A ends with four ones, frame B begins with two
        mem[0] = 8'hF0;
        run_frame(1, 1'b0);
        mem[0] = 8'h03;
        mem[1] = 8'h00;
        run_frame(2, 1'b0);   // R10 checked by absence of a stuff symbol

        // R3: start pulse mid-frame is ignored
        for (int i = 0; i < 6; i++) mem[i] = 8'($urandom);
        run_frame(6, 1'b1);

        // random payloads
        for (int f = 0; f < 8; f++) begin
            int len;
            len = int'($urandom % 20);
            for (int i = 0; i < 20; i++)
                mem[i] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
            run_frame(len, 1'b0);
        end

        @(negedge clk);
        check("R11 idle at end", 32'(busy_o), 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule